// File: doc/BRIEF.md
# Cursor and Blink Attribute Generator

This block sits in the pixel path of a character display, between the font lookup and the column drivers. For every pixel row the display scans, it receives the index of the character cell being scanned, the pixel row inside that cell, and the raw font pixels for that row. It compares the scanned cell with the address counter. When the two match, it applies the enabled effects to the pixels: an underline cursor on the bottom pixel row of the cell, a blink that alternates the whole cell between blank and its normal pattern, or both.

The blink phase comes from a free-running divider clocked by the oscillator clock, so the blink rate scales with the oscillator frequency. With the default division of 99,900 cycles, a 270 kHz oscillator gives a 370 ms interval between phase changes. The pixel output is registered and follows the scan inputs by one clock. The asynchronous active-low reset is released through a two-stage synchronizer. The first clock edge after the release of `rst_n` loads the first stage, the second loads the second stage, and the third edge is the first edge on which the divider counts.

Top module: `cbg_attr_gen`

## Requirements
- R1: While reset is asserted, `pix_o` is 0, and the blink phase after reset starts in the visible (normal) half.
- R2: When the scanned cell differs from the address counter, `pix_o` one clock later equals the `font_px_i` value that was applied, whatever the cursor and blink controls are.
- R3: When `cursor_on_i` is 1 and the scanned cell matches the address counter, the last pixel row (row index ROWS-1 = 7, with row 0 at the top) gives all-ones on every one of the COLS columns one clock later. The other rows of that cell pass the font unchanged.
- R4: When `blink_on_i` is 1, the scanned cell matches, and the blink phase is blank, `pix_o` is all zeros one clock later. This includes the cursor row.
- R5: When `blink_on_i` is 1 and the blink phase is visible, the matching cell shows its normal font. `blink_on_i` at 0 never blanks a cell.
- R6: The blink phase toggles once every BLINK_DIV clock edges (default 99,900) counted from the first counting edge after reset release. Output captured on the k-th counting edge uses phase ((k-1)/BLINK_DIV) mod 2, where 0 means visible and 1 means blank.
- R7: An address counter value of VIS_CELLS (default 80) or above produces no effect, even when the scanned cell index equals it. Value VIS_CELLS-1 still produces the effect.
- R8: When the cursor and blink are both enabled, the matching cell shows the cursor in the visible phase and is fully blank in the blank phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; drives the divider and the pixel register |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_cell_i | input | CELL_W | Index of the character cell being scanned |
| scan_row_i | input | ROW_W | Pixel row inside the scanned cell, 0 at the top |
| font_px_i | input | COLS | Raw font pixels for this row, bit COLS-1 the leftmost column |
| addr_ctr_i | input | CELL_W | Address counter: the cell that carries the cursor and blink |
| cursor_on_i | input | 1 | Enables the underline cursor |
| blink_on_i | input | 1 | Enables the cell blink |
| pix_o | output | COLS | Pixels after the overlay, one clock after the inputs |

## Verification
The bench targets the cursor row boundary (rows 6 and 7 of the addressed cell). A design with the wrong row index would underline the wrong row or none. It probes the visible-range edge at 79 and 80. A design with an off-by-one compare would decorate address 80 or drop address 79. It holds cursor and blink together across several blink periods. A design that let the cursor override the blank phase would show a lit underline when the cell should be dark. A design with a divider off by one edge would flip the phase one sample early or late against the bench's edge count. A mid-run reset confirms that the blink restarts in the visible phase.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

  // Blink phase: the visible half shows the cell, the blank half hides it.
  typedef enum logic {
    PH_SHOW  = 1'b0,
    PH_BLANK = 1'b1
  } blink_ph_e;

  localparam int unsigned DEF_COLS      = 5;
  localparam int unsigned DEF_ROWS      = 8;
  localparam int unsigned DEF_CELL_W    = 7;
  localparam int unsigned DEF_VIS_CELLS = 80;
  localparam int unsigned DEF_BLINK_DIV = 99900;

endpackage

// File: rtl/cbg_blink_div.sv
module cbg_blink_div
  import cbg_pkg::*;
#(
  parameter int unsigned DIV = DEF_BLINK_DIV,
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic      clk,
  input  logic      rst_ni,
  output blink_ph_e phase_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  blink_ph_e        phase_q, phase_d;
  logic             wrap;

  // Next-state logic
  always_comb begin
    wrap    = (cnt_q == CNT_W'(DIV - 1));
    cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
    phase_d = phase_q;
    if (wrap) begin
      phase_d = (phase_q == PH_SHOW) ? PH_BLANK : PH_SHOW;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SHOW;
    end else if (wrap) begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  // R6: the counter stays inside its division range
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DIV - 1));

  // R6: a phase change happens only right after the last count of a period
  assert_phase_only_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(phase_q) |-> $past(cnt_q) == CNT_W'(DIV - 1));

  // R6: the last count of a period always flips the phase
  assert_wrap_flips_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q == CNT_W'(DIV - 1) |=> phase_q != $past(phase_q));

endmodule

// File: rtl/cbg_cell_match.sv
module cbg_cell_match
  import cbg_pkg::*;
#(
  parameter int unsigned CELL_W    = DEF_CELL_W,
  parameter int unsigned VIS_CELLS = DEF_VIS_CELLS
) (
  input  logic [CELL_W-1:0] scan_cell_i,
  input  logic [CELL_W-1:0] addr_ctr_i,
  output logic              hit_o
);

  logic same_cell;
  logic in_range;

  always_comb begin
    same_cell = (scan_cell_i == addr_ctr_i);
    in_range  = ({1'b0, addr_ctr_i} < (CELL_W + 1)'(VIS_CELLS));
    hit_o     = same_cell & in_range;
  end

endmodule

// File: rtl/cbg_pix_overlay.sv
module cbg_pix_overlay
  import cbg_pkg::*;
#(
  parameter int unsigned COLS = DEF_COLS,
  parameter int unsigned ROWS = DEF_ROWS,
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             hit_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COLS-1:0]  font_i,
  input  logic             cursor_on_i,
  input  logic             blink_on_i,
  input  blink_ph_e        phase_i,
  output logic [COLS-1:0]  pix_o
);

  localparam logic [ROW_W-1:0] CURSOR_ROW = ROW_W'(ROWS - 1);

  logic blank;
  logic underline;

  always_comb begin
    blank     = hit_i & blink_on_i & (phase_i == PH_BLANK);
    underline = hit_i & cursor_on_i & (row_i == CURSOR_ROW);
  end

  // Same selection for every font column; blank wins over the cursor
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign pix_o[c] = blank ? 1'b0 : (underline ? 1'b1 : font_i[c]);
  end

endmodule

// File: rtl/cbg_attr_gen.sv
module cbg_attr_gen
  import cbg_pkg::*;
#(
  parameter int unsigned COLS      = DEF_COLS,
  parameter int unsigned ROWS      = DEF_ROWS,
  parameter int unsigned CELL_W    = DEF_CELL_W,
  parameter int unsigned VIS_CELLS = DEF_VIS_CELLS,
  parameter int unsigned BLINK_DIV = DEF_BLINK_DIV,
  localparam int unsigned ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CELL_W-1:0] scan_cell_i,
  input  logic [ROW_W-1:0]  scan_row_i,
  input  logic [COLS-1:0]   font_px_i,
  input  logic [CELL_W-1:0] addr_ctr_i,
  input  logic              cursor_on_i,
  input  logic              blink_on_i,
  output logic [COLS-1:0]   pix_o
);

  // Reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i = rst_sync_q[1];

  blink_ph_e       phase;
  logic            hit;
  logic [COLS-1:0] pix_d, pix_q;

  cbg_blink_div #(
    .DIV(BLINK_DIV)
  ) u_div (
    .clk    (clk),
    .rst_ni (rst_i),
    .phase_o(phase)
  );

  cbg_cell_match #(
    .CELL_W   (CELL_W),
    .VIS_CELLS(VIS_CELLS)
  ) u_match (
    .scan_cell_i(scan_cell_i),
    .addr_ctr_i (addr_ctr_i),
    .hit_o      (hit)
  );

  cbg_pix_overlay #(
    .COLS(COLS),
    .ROWS(ROWS)
  ) u_ovl (
    .hit_i      (hit),
    .row_i      (scan_row_i),
    .font_i     (font_px_i),
    .cursor_on_i(cursor_on_i),
    .blink_on_i (blink_on_i),
    .phase_i    (phase),
    .pix_o      (pix_d)
  );

  // Output register
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pix_q <= '0;
    end else begin
      pix_q <= pix_d;
    end
  end

  assign pix_o = pix_q;

  // R2: cells other than the addressed one carry the font through untouched
  assert_pass_font_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (scan_cell_i != addr_ctr_i) |=> pix_o == $past(font_px_i));

  // R3: the cursor lights the whole last row of the addressed cell
  assert_cursor_row_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (hit && cursor_on_i && (phase == PH_SHOW) && (scan_row_i == ROW_W'(ROWS - 1)))
      |=> pix_o == '1);

  // R4: the blank half of a blink darkens the addressed cell completely
  assert_blank_cell_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (hit && blink_on_i && (phase == PH_BLANK)) |=> pix_o == '0);

  // R7: an address counter beyond the visible cells leaves the font alone
  assert_invisible_addr_R7: assert property (@(posedge clk) disable iff (!rst_i)
    ({1'b0, addr_ctr_i} >= (CELL_W + 1)'(VIS_CELLS)) |=> pix_o == $past(font_px_i));

endmodule

// File: tb/cbg_attr_gen_tb.sv
module cbg_attr_gen_tb;

  localparam int TB_DIV = 10;

  logic       clk;
  logic       rst_n;
  logic [6:0] scan_cell;
  logic [2:0] scan_row;
  logic [4:0] font_px;
  logic [6:0] addr_ctr;
  logic       cursor_on;
  logic       blink_on;
  logic [4:0] pix;

  int n_chk;
  int n_fail;
  int ecnt;

  cbg_attr_gen #(
    .BLINK_DIV(TB_DIV)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_cell_i(scan_cell),
    .scan_row_i (scan_row),
    .font_px_i  (font_px),
    .addr_ctr_i (addr_ctr),
    .cursor_on_i(cursor_on),
    .blink_on_i (blink_on),
    .pix_o      (pix)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Edges since the bench released reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  // Expected blink phase of the sample taken after edge ecnt (R6)
  function automatic bit blank_now();
    return (((ecnt - 3) / TB_DIV) % 2) == 1;
  endfunction

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b (edge %0d)", tag, act, exp, ecnt);
    end
  endtask

  task automatic drive(input logic [6:0] c, input logic [2:0] r, input logic [4:0] f,
                       input logic [6:0] a, input logic cu, input logic bl);
    scan_cell = c; scan_row = r; font_px = f; addr_ctr = a; cursor_on = cu; blink_on = bl;
  endtask

  // {cell, row, font, addr, cursor, blink, expected visible, expected blank}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {7'd5,  3'd2, 5'b10101, 7'd3,  1'b1, 1'b1, 5'b10101, 5'b10101}, // R2 other cell
    {7'd3,  3'd7, 5'b00000, 7'd3,  1'b1, 1'b0, 5'b11111, 5'b11111}, // R3 cursor row
    {7'd3,  3'd4, 5'b01110, 7'd3,  1'b1, 1'b0, 5'b01110, 5'b01110}, // R3 other row
    {7'd3,  3'd2, 5'b11011, 7'd3,  1'b0, 1'b1, 5'b11011, 5'b00000}, // R4 / R5 blink
    {7'd3,  3'd7, 5'b00100, 7'd3,  1'b1, 1'b1, 5'b11111, 5'b00000}, // R8 both
    {7'd90, 3'd7, 5'b00100, 7'd90, 1'b1, 1'b1, 5'b00100, 5'b00100}, // R7 far out
    {7'd80, 3'd7, 5'b10001, 7'd80, 1'b1, 1'b1, 5'b10001, 5'b10001}, // R7 first invisible
    {7'd79, 3'd7, 5'b10001, 7'd79, 1'b1, 1'b0, 5'b11111, 5'b11111}, // R7 last visible
    {7'd0,  3'd7, 5'b01010, 7'd0,  1'b0, 1'b0, 5'b01010, 5'b01010}, // R5 controls off
    {7'd1,  3'd7, 5'b01010, 7'd0,  1'b1, 1'b1, 5'b01010, 5'b01010}, // R2 neighbour cell
    {7'd0,  3'd0, 5'b11111, 7'd0,  1'b0, 1'b1, 5'b11111, 5'b00000}, // R4 cell zero
    {7'd8,  3'd6, 5'b10000, 7'd8,  1'b1, 1'b0, 5'b10000, 5'b10000}  // R3 row above cursor
  };

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    drive(7'd3, 3'd7, 5'b11111, 7'd3, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk(pix, 5'b00000, "R1 output during reset");

    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk, three passes so both blink phases are met
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < NV; i++) begin
        drive(VEC[i][33:27], VEC[i][26:24], VEC[i][23:19], VEC[i][18:12],
              VEC[i][11], VEC[i][10]);
        @(negedge clk);
        chk(pix, blank_now() ? VEC[i][4:0] : VEC[i][9:5], "R2/R3/R4/R5/R7/R8 table");
      end
    end

    // R6 and R8: hold cursor and blink on the cursor row for three periods
    drive(7'd4, 3'd7, 5'b01010, 7'd4, 1'b1, 1'b1);
    for (int k = 0; k < 3 * TB_DIV; k++) begin
      @(negedge clk);
      chk(pix, blank_now() ? 5'b00000 : 5'b11111, "R6 blink period with cursor");
    end

    // R1: reset in mid-run clears the output at once
    rst_n = 1'b0;
    #1;
    chk(pix, 5'b00000, "R1 asynchronous reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pix, 5'b00000, "R1 held during reset release");
    @(negedge clk);
    // R1: first sample after reset is in the visible phase
    chk(pix, 5'b11111, "R1 phase restarts visible");
    drive(7'd4, 3'd3, 5'b00110, 7'd4, 1'b0, 1'b1);
    for (int k = 0; k < TB_DIV + 2; k++) begin
      @(negedge clk);
      chk(pix, blank_now() ? 5'b00000 : 5'b00110, "R6 blink after reset");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule